// File: doc/BRIEF.md
# Byte-Wide Multi-Cycle Processor Core

This block is a small 8-bit processor core. It holds eight 8-bit general registers and a 256-byte memory that stores both code and data. It reads one instruction byte per clock cycle, decodes it and executes it. It knows four operations: load an immediate into a register, print a register, multiply two registers, and stop. A byte value that is not one of the four opcodes stops the core with a fault indication. This indication is kept apart from a normal stop.

A host loads a program through a byte-wide load port. While `load_en` is high the core stays idle, and each cycle with `load_we` high writes `load_data` to the next memory address, starting from zero after reset. When `load_en` drops, execution starts at address zero. Each print presents a register value on `out_data` with a one-cycle `out_valid` strobe.

Top module: `byte_cpu`

## Requirements
- R1: After reset `out_valid`, `halted` and `fault` are low, registers 0 to 6 read 0 and register 7 reads 0xF4.
- R2: Reset clears every memory byte to 0, so a program loaded before a reset is gone after it. Because 0x00 is not a valid opcode, running the cleared memory faults at once.
- R3: While `load_en` is high the core fetches and prints nothing. Each cycle with `load_we` high writes `load_data` at the next address, counting up from 0x00 after reset. When `load_en` goes low, execution starts at address 0x00.
- R4: Opcode 0x82 is three bytes (opcode, register, value). It writes the value into the register and continues at the following byte.
- R5: Opcode 0x47 is two bytes (opcode, register). It drives the register value on `out_data` with `out_valid` high for exactly one cycle.
- R6: Opcode 0xA2 is three bytes (opcode, register A, register B). It writes the low 8 bits of A times B into A and leaves B unchanged.
- R7: Opcode 0x01 raises `halted`. It stays high, and no further print appears, until reset.
- R8: Any other opcode raises `fault` with `halted` low. `fault` stays high until reset.
- R9: Only the low 3 bits of a register byte select the register (0x0B selects register 3).
- R10: The program counter wraps from 0xFF to 0x00, including in the middle of an instruction's operand bytes.
- R11: Each byte fetch takes one cycle, and the execute step takes one more. The first print of a program that starts with 0x47 shows `out_valid` on the 4th rising edge after `load_en` is seen low. A second 0x47 that follows directly prints 3 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Holds the core idle and enables program loading |
| load_we | input | 1 | Writes `load_data` at the next load address |
| load_data | input | 8 | Program byte to load |
| out_valid | output | 1 | One-cycle strobe for a print |
| out_data | output | 8 | Printed register value |
| halted | output | 1 | Normal stop reached |
| fault | output | 1 | Stopped on an unknown opcode |

## Verification
A fetch step that goes wrong shifts every later byte out of step. An operand byte is then decoded as an opcode, and within a few cycles this shows either as `fault` or as prints with wrong values and timing. A bad register write or a bad multiply shows on the next print of that register, three cycles after its opcode is fetched. Stop-state mistakes show at once on `halted` and `fault`, or as a print that follows a stop. The bench therefore compares print values, the cycle of each print and the stop outputs against sequences worked out by hand, including a program that runs across the top of memory.

// File: rtl/bcpu_pkg.sv
package bcpu_pkg;

    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int REG_CNT   = 8;
    localparam int REG_IDX_W = $clog2(REG_CNT);
    localparam int MEM_DEPTH = 1 << ADDR_W;

    localparam logic [DATA_W-1:0] TOP_REG_INIT = 8'hF4;

    localparam logic [DATA_W-1:0] OP_STOP  = 8'h01;
    localparam logic [DATA_W-1:0] OP_LOADI = 8'h82;
    localparam logic [DATA_W-1:0] OP_PRINT = 8'h47;
    localparam logic [DATA_W-1:0] OP_MULT  = 8'hA2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OPA,
        ST_OPB,
        ST_EXEC,
        ST_HALT,
        ST_FAULT
    } cpu_state_e;

    typedef struct packed {
        cpu_state_e             state;
        logic [ADDR_W-1:0]      pc;
        logic [ADDR_W-1:0]      ld_ptr;
        logic [DATA_W-1:0]      ir;
        logic [REG_IDX_W-1:0]   opa;
        logic [DATA_W-1:0]      opb;
        logic                   prn_valid;
        logic [DATA_W-1:0]      prn_data;
    } ctrl_regs_t;

endpackage

// File: rtl/byte_mem.sv
module byte_mem #(
    parameter int DW    = bcpu_pkg::DATA_W,
    parameter int AW    = bcpu_pkg::ADDR_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/reg_bank.sv
module reg_bank #(
    parameter int             DW       = bcpu_pkg::DATA_W,
    parameter int             NREGS    = bcpu_pkg::REG_CNT,
    parameter logic [DW-1:0]  TOP_INIT = bcpu_pkg::TOP_REG_INIT,
    localparam int            IW       = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ra,
    input  logic [IW-1:0] rb,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b
);

    logic [DW-1:0] regs_d [NREGS];
    logic [DW-1:0] regs_q [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            regs_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= (i == NREGS - 1) ? TOP_INIT : '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata_a = regs_q[ra];
    assign rdata_b = regs_q[rb];

endmodule

// File: rtl/trunc_mul.sv
module trunc_mul #(
    parameter int W = bcpu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p
);

    logic [W-1:0] partial [W];

    for (genvar g = 0; g < W; g++) begin : g_pp
        assign partial[g] = b[g] ? (a << g) : '0;
    end

    always_comb begin
        p = '0;
        for (int i = 0; i < W; i++) begin
            p = p + partial[i];
        end
    end

endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
    import bcpu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic                 load_we,
    input  logic [DATA_W-1:0]    load_data,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic [DATA_W-1:0]    reg_a_data,
    input  logic [DATA_W-1:0]    mul_result,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_waddr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic [ADDR_W-1:0]    mem_raddr,
    output logic                 reg_we,
    output logic [REG_IDX_W-1:0] reg_waddr,
    output logic [DATA_W-1:0]    reg_wdata,
    output logic [REG_IDX_W-1:0] reg_ra,
    output logic [REG_IDX_W-1:0] reg_rb,
    output logic                 out_valid,
    output logic [DATA_W-1:0]    out_data,
    output logic                 halted,
    output logic                 fault
);

    localparam ctrl_regs_t RST_VAL = '{
        state:     ST_IDLE,
        pc:        '0,
        ld_ptr:    '0,
        ir:        '0,
        opa:       '0,
        opb:       '0,
        prn_valid: 1'b0,
        prn_data:  '0
    };

    ctrl_regs_t r_d;
    ctrl_regs_t r_q;

    always_comb begin
        r_d           = r_q;
        r_d.prn_valid = 1'b0;
        mem_we        = 1'b0;
        mem_waddr     = r_q.ld_ptr;
        mem_wdata     = load_data;
        reg_we        = 1'b0;
        reg_waddr     = r_q.opa;
        reg_wdata     = r_q.opb;

        case (r_q.state)
            ST_IDLE: begin
                if (load_en) begin
                    if (load_we) begin
                        mem_we     = 1'b1;
                        r_d.ld_ptr = r_q.ld_ptr + 1'b1;
                    end
                end else begin
                    r_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                r_d.ir = mem_rdata;
                r_d.pc = r_q.pc + 1'b1;
                case (mem_rdata)
                    OP_STOP:                     r_d.state = ST_HALT;
                    OP_LOADI, OP_PRINT, OP_MULT: r_d.state = ST_OPA;
                    default:                     r_d.state = ST_FAULT;
                endcase
            end
            ST_OPA: begin
                r_d.opa   = mem_rdata[REG_IDX_W-1:0];
                r_d.pc    = r_q.pc + 1'b1;
                r_d.state = (r_q.ir == OP_PRINT) ? ST_EXEC : ST_OPB;
            end
            ST_OPB: begin
                r_d.opb   = mem_rdata;
                r_d.pc    = r_q.pc + 1'b1;
                r_d.state = ST_EXEC;
            end
            ST_EXEC: begin
                r_d.state = ST_FETCH;
                case (r_q.ir)
                    OP_LOADI: begin
                        reg_we    = 1'b1;
                        reg_wdata = r_q.opb;
                    end
                    OP_PRINT: begin
                        r_d.prn_valid = 1'b1;
                        r_d.prn_data  = reg_a_data;
                    end
                    OP_MULT: begin
                        reg_we    = 1'b1;
                        reg_wdata = mul_result;
                    end
                    default: r_d.state = ST_FAULT;
                endcase
            end
            ST_HALT:  r_d.state = ST_HALT;
            ST_FAULT: r_d.state = ST_FAULT;
            default:  r_d.state = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_raddr = r_q.pc;
    assign reg_ra    = r_q.opa;
    assign reg_rb    = r_q.opb[REG_IDX_W-1:0];
    assign out_valid = r_q.prn_valid;
    assign out_data  = r_q.prn_data;
    assign halted    = (r_q.state == ST_HALT);
    assign fault     = (r_q.state == ST_FAULT);

endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
    import bcpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              load_we,
    input  logic [DATA_W-1:0] load_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              halted,
    output logic              fault
);

    logic                 mem_we;
    logic [ADDR_W-1:0]    mem_waddr;
    logic [DATA_W-1:0]    mem_wdata;
    logic [ADDR_W-1:0]    mem_raddr;
    logic [DATA_W-1:0]    mem_rdata;
    logic                 reg_we;
    logic [REG_IDX_W-1:0] reg_waddr;
    logic [DATA_W-1:0]    reg_wdata;
    logic [REG_IDX_W-1:0] reg_ra;
    logic [REG_IDX_W-1:0] reg_rb;
    logic [DATA_W-1:0]    reg_a_data;
    logic [DATA_W-1:0]    reg_b_data;
    logic [DATA_W-1:0]    mul_result;

    byte_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    reg_bank #(.DW(DATA_W), .NREGS(REG_CNT), .TOP_INIT(TOP_REG_INIT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .waddr   (reg_waddr),
        .wdata   (reg_wdata),
        .ra      (reg_ra),
        .rb      (reg_rb),
        .rdata_a (reg_a_data),
        .rdata_b (reg_b_data)
    );

    trunc_mul #(.W(DATA_W)) u_mul (
        .a (reg_a_data),
        .b (reg_b_data),
        .p (mul_result)
    );

    core_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .load_we    (load_we),
        .load_data  (load_data),
        .mem_rdata  (mem_rdata),
        .reg_a_data (reg_a_data),
        .mul_result (mul_result),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .mem_raddr  (mem_raddr),
        .reg_we     (reg_we),
        .reg_waddr  (reg_waddr),
        .reg_wdata  (reg_wdata),
        .reg_ra     (reg_ra),
        .reg_rb     (reg_rb),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .halted     (halted),
        .fault      (fault)
    );

endmodule

// File: rtl/byte_cpu_checks.sv
module byte_cpu_checks (
    input logic clk,
    input logic rst_n,
    input logic out_valid,
    input logic halted,
    input logic fault
);

    AST_PRINT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R5

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R7

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !out_valid); // R7

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault); // R8

    AST_STOP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(halted && fault)); // R8

endmodule

bind byte_cpu byte_cpu_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .halted    (halted),
    .fault     (fault)
);

// File: tb/tb_byte_cpu.sv
`timescale 1ns/1ps
module tb_byte_cpu;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_en = 1'b1;
    logic       load_we = 1'b0;
    logic [7:0] load_data = 8'h00;
    logic       out_valid;
    logic [7:0] out_data;
    logic       halted;
    logic       fault;

    int ntests = 0;
    int nfail  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [7:0] prog [256];
    logic [7:0] log_val [16];
    int         log_cyc [16];
    int         nlog = 0;
    int         rel_cyc = 0;

    // {a, b, expected low byte of a*b}
    localparam logic [23:0] VECS [8] = '{
        {8'h03, 8'h05, 8'h0F},
        {8'h00, 8'h4D, 8'h00},
        {8'hFF, 8'hFF, 8'h01},
        {8'h10, 8'h10, 8'h00},
        {8'h01, 8'hC8, 8'hC8},
        {8'h0C, 8'h0D, 8'h9C},
        {8'hC8, 8'h03, 8'h58},
        {8'h07, 8'h25, 8'h03}
    };

    byte_cpu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_we   (load_we),
        .load_data (load_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .halted    (halted),
        .fault     (fault)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst_n) begin
            nlog = 0;
        end else if (out_valid) begin
            if (nlog < 16) begin
                log_val[nlog] = out_data;
                log_cyc[nlog] = cyc;
            end
            nlog = nlog + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
    endtask

    task automatic do_reset();
        load_en = 1'b1;
        load_we = 1'b0;
        rst_n   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_bytes(input int n);
        for (int i = 0; i < n; i++) begin
            load_data = prog[i];
            load_we   = 1'b1;
            @(negedge clk);
        end
        load_we = 1'b0;
    endtask

    task automatic start_run();
        load_en = 1'b0;
        rel_cyc = cyc;
    endtask

    task automatic wait_stop(input int maxc);
        for (int i = 0; i < maxc; i++) begin
            if (halted || fault) break;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        clear_prog();
        do_reset();

        // R1: reset state at the ports
        chk("R1 out_valid after reset", out_valid, 0);
        chk("R1 halted after reset", halted, 0);
        chk("R1 fault after reset", fault, 0);

        // R4 R6: multiply vectors, print product then B
        for (int v = 0; v < 8; v++) begin
            clear_prog();
            prog[0] = 8'h82; prog[1] = 8'h01; prog[2] = VECS[v][23:16];
            prog[3] = 8'h82; prog[4] = 8'h02; prog[5] = VECS[v][15:8];
            prog[6] = 8'hA2; prog[7] = 8'h01; prog[8] = 8'h02;
            prog[9] = 8'h47; prog[10] = 8'h01;
            prog[11] = 8'h47; prog[12] = 8'h02;
            prog[13] = 8'h01;
            do_reset();
            load_bytes(14);
            start_run();
            wait_stop(200);
            chk("R6 product value", log_val[0], VECS[v][7:0]);
            chk("R6 operand B unchanged", log_val[1], VECS[v][15:8]);
            chk("R4 print count", nlog, 2);
            chk("R7 halted after vector", halted, 1);
        end

        // R3 R11 R1: idle while loading, then timing and reset register values
        clear_prog();
        prog[0] = 8'h47; prog[1] = 8'h07;
        prog[2] = 8'h47; prog[3] = 8'h00;
        prog[4] = 8'h01;
        do_reset();
        load_bytes(5);
        repeat (30) @(negedge clk);
        chk("R3 no print while load_en high", nlog, 0);
        chk("R3 not halted while load_en high", halted, 0);
        chk("R3 no fault while load_en high", fault, 0);
        start_run();
        wait_stop(100);
        repeat (10) @(negedge clk);
        chk("R1 register 7 reset value", log_val[0], 8'hF4);
        chk("R1 register 0 reset value", log_val[1], 8'h00);
        chk("R11 first print cycle", log_cyc[0] - rel_cyc, 4);
        chk("R11 second print cycle", log_cyc[1] - rel_cyc, 7);
        chk("R5 one strobe per print", nlog, 2);
        chk("R7 halted stays", halted, 1);
        chk("R7 halt is not fault", fault, 0);

        // R8: unknown opcode after one print
        clear_prog();
        prog[0] = 8'h47; prog[1] = 8'h07; prog[2] = 8'h55; prog[3] = 8'h47; prog[4] = 8'h07;
        do_reset();
        load_bytes(5);
        start_run();
        wait_stop(100);
        repeat (20) @(negedge clk);
        chk("R8 fault raised", fault, 1);
        chk("R8 halted low on fault", halted, 0);
        chk("R8 no print after fault", nlog, 1);

        // R2: loaded bytes vanish across reset
        clear_prog();
        prog[0] = 8'h47; prog[1] = 8'h07; prog[2] = 8'h01;
        do_reset();
        load_bytes(3);
        do_reset();
        start_run();
        wait_stop(100);
        repeat (5) @(negedge clk);
        chk("R2 cleared memory faults", fault, 1);
        chk("R2 nothing printed", nlog, 0);

        // R9: register byte 0x0B selects register 3
        clear_prog();
        prog[0] = 8'h82; prog[1] = 8'h0B; prog[2] = 8'h5A;
        prog[3] = 8'h47; prog[4] = 8'h03;
        prog[5] = 8'h01;
        do_reset();
        load_bytes(6);
        start_run();
        wait_stop(100);
        chk("R9 masked register index", log_val[0], 8'h5A);

        // R6: multiply a register by itself, 11*11 = 0x79
        clear_prog();
        prog[0] = 8'h82; prog[1] = 8'h04; prog[2] = 8'h0B;
        prog[3] = 8'hA2; prog[4] = 8'h04; prog[5] = 8'h04;
        prog[6] = 8'h47; prog[7] = 8'h04;
        prog[8] = 8'h01;
        do_reset();
        load_bytes(9);
        start_run();
        wait_stop(100);
        chk("R6 square of register", log_val[0], 8'h79);

        // R10: immediate fetched from address 0x00 after wrap
        clear_prog();
        prog[0] = 8'h82; prog[1] = 8'h47; prog[2] = 8'h06;
        prog[3] = 8'h47; prog[4] = 8'h07;
        for (int k = 0; k < 83; k++) begin
            prog[5 + 3 * k] = 8'h82;
            prog[6 + 3 * k] = 8'h00;
            prog[7 + 3 * k] = 8'h00;
        end
        prog[254] = 8'h82; prog[255] = 8'h06;
        do_reset();
        load_bytes(256);
        start_run();
        for (int i = 0; i < 2000; i++) begin
            if (nlog >= 2 || fault || halted) break;
            @(negedge clk);
        end
        chk("R10 print before wrap", log_val[0], 8'h06);
        chk("R10 immediate read across wrap", log_val[1], 8'h82);
        chk("R10 no fault across wrap", fault, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule